// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block is the landing zone for message-signalled interrupts. An interrupt message arrives as a single memory write. The write address picks one of 16 groups and one of 8 vector registers inside that group. The write data is a vector number from 0 to 15, and the block sets that vector's pending bit in the addressed register. Each group raises its own level interrupt line while any of its vector registers holds a pending bit.

A handler first reads the group's summary register. That register shows which of the group's 8 vector registers are non-empty. The handler then reads those vector registers. Each such read returns the pending bits and clears them in the same access. The summary always shows the live state, so a handler that rereads it after draining sees any message that arrived in the meantime.

Writes and reads use separate valid/ready request channels. Both ready outputs are tied high, so the block never applies back-pressure. A read produces exactly one response with `rsp_valid` one cycle after the request is accepted. The response channel has no ready input, so the requester must take every response in the cycle it appears.

Top module: `msi_term_bank`

## Requirements
- R1: Vector register i of group g is decoded at byte offset (g << 19) | (i << 16). The summary of group g is decoded at 0x800000 | (g << 16). Any offset with a non-zero value in bits 15..0 is unmapped.
- R2: An accepted write of data value v (0..15) to a vector register sets bit v of that register and changes no other bit.
- R3: An accepted read of a vector register returns its pending bits in rsp_data[15:0], with bits 31..16 zero, one cycle after the request. The register is zero afterwards.
- R4: Bit i (0..7) of a group's summary is 1 exactly when vector register i of that group is non-zero. Bits 31..8 read 0. The summary shows bits set by writes that land after an earlier read.
- R5: irq_o[g] is high exactly while the summary of group g is non-zero.
- R6: If a write and a read hit the same vector register in the same cycle, the read returns the value from before the write. The newly set bit remains pending after the clear.
- R7: These writes leave every register unchanged: a write with data 16 or above, a write to a summary offset, and a write to an unmapped offset.
- R8: A read of an unmapped offset returns zero and clears nothing.
- R9: Reset clears every pending bit and drives irq_o and rsp_valid low.
- R10: wr_ready and rd_ready are always 1. rsp_valid is high in exactly the cycle after each accepted read.
- R11: Once every vector register has been read once with no new writes, every summary reads zero and every irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready (always 1) |
| wr_addr | input | 24 | Write byte offset |
| wr_data | input | 32 | Write data (vector number) |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready (always 1) |
| rd_addr | input | 24 | Read byte offset |
| rsp_valid | output | 1 | Read response valid, one cycle after the request |
| rsp_data | output | 32 | Read response data |
| irq_o | output | 16 | Per-group level interrupt |

## Verification
Two functions can fall in the same cycle: setting a vector bit through the write channel and clearing a register through the read channel. The bench drives both channels in one cycle at the same vector register. It expects the read to return the old contents. It then issues a second read and expects only the newly written bit. The bench also tries the same collision on different registers, where it expects the write to land intact and the read to drain only its own target.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  localparam int unsigned DEF_GROUPS  = 16;
  localparam int unsigned DEF_IDX     = 8;
  localparam int unsigned DEF_VECS    = 16;
  localparam int unsigned REG_SHIFT   = 16;
  localparam int unsigned DATA_W      = 32;

  typedef enum logic [1:0] {
    RGN_NONE    = 2'd0,
    RGN_VECTOR  = 2'd1,
    RGN_SUMMARY = 2'd2
  } region_e;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_term_pkg::*;
#(
  parameter int unsigned GRP_W  = 4,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = REG_SHIFT + IDX_W + GRP_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [GRP_W-1:0]  grp,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned GRP_LSB_V = REG_SHIFT + IDX_W;
  localparam int unsigned SUM_PAD_W = ADDR_W - 1 - (REG_SHIFT + GRP_W);

  logic low_clear;
  logic sum_pad_clear;

  assign low_clear     = (addr[REG_SHIFT-1:0] == '0);
  assign sum_pad_clear = (addr[ADDR_W-2 -: SUM_PAD_W] == '0);

  always_comb begin
    region = RGN_NONE;
    grp    = '0;
    idx    = '0;
    if (low_clear) begin
      if (!addr[ADDR_W-1]) begin
        region = RGN_VECTOR;
        grp    = addr[GRP_LSB_V +: GRP_W];
        idx    = addr[REG_SHIFT +: IDX_W];
      end else if (sum_pad_clear) begin
        region = RGN_SUMMARY;
        grp    = addr[REG_SHIFT +: GRP_W];
      end
    end
  end
endmodule

// File: rtl/msi_vec_reg.sv
module msi_vec_reg #(
  parameter int unsigned VECS  = 16,
  parameter int unsigned VEC_W = $clog2(VECS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             clr_en,
  output logic [VECS-1:0]  bits
);
  logic [VECS-1:0] set_mask;
  logic [VECS-1:0] kept;

  assign set_mask = set_en ? (VECS'(1) << set_vec) : '0;
  assign kept     = clr_en ? '0 : bits;

  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else        bits <= kept | set_mask;
  end

  // R2
  set_bit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits[$past(set_vec)]);

  // R3
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> (bits == '0));

  // R6
  set_survives_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_en) |=> ($countones(bits) == 1));

  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !set_en) |=> $stable(bits));
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
#(
  parameter int unsigned GROUPS = DEF_GROUPS,
  parameter int unsigned IDXS   = DEF_IDX,
  parameter int unsigned VECS   = DEF_VECS,
  localparam int unsigned GRP_W  = $clog2(GROUPS),
  localparam int unsigned IDX_W  = $clog2(IDXS),
  localparam int unsigned VEC_W  = $clog2(VECS),
  localparam int unsigned ADDR_W = REG_SHIFT + IDX_W + GRP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [GROUPS-1:0] irq_o
);
  region_e          wr_rgn, rd_rgn;
  logic [GRP_W-1:0] wr_grp, rd_grp;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             wr_take, rd_take;
  logic             vec_ok;

  logic [VECS-1:0]  bank    [GROUPS][IDXS];
  logic [IDXS-1:0]  summary [GROUPS];

  assign wr_ready = 1'b1;
  assign rd_ready = 1'b1;
  assign vec_ok   = (wr_data < DATA_W'(VECS));
  assign wr_take  = wr_valid && (wr_rgn == RGN_VECTOR) && vec_ok;
  assign rd_take  = rd_valid && (rd_rgn == RGN_VECTOR);

  msi_addr_decode #(.GRP_W(GRP_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) wr_dec_i (
    .addr(wr_addr), .region(wr_rgn), .grp(wr_grp), .idx(wr_idx));

  msi_addr_decode #(.GRP_W(GRP_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) rd_dec_i (
    .addr(rd_addr), .region(rd_rgn), .grp(rd_grp), .idx(rd_idx));

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar i = 0; i < IDXS; i++) begin : g_idx
      logic hit_set, hit_clr;
      assign hit_set = wr_take && (wr_grp == GRP_W'(g)) && (wr_idx == IDX_W'(i));
      assign hit_clr = rd_take && (rd_grp == GRP_W'(g)) && (rd_idx == IDX_W'(i));
      msi_vec_reg #(.VECS(VECS), .VEC_W(VEC_W)) vreg_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(hit_set), .set_vec(wr_data[VEC_W-1:0]),
        .clr_en(hit_clr), .bits(bank[g][i]));
      assign summary[g][i] = |bank[g][i];
    end
    assign irq_o[g] = |summary[g];
  end

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    unique case (rd_rgn)
      RGN_VECTOR:  rd_word = DATA_W'(bank[rd_grp][rd_idx]);
      RGN_SUMMARY: rd_word = DATA_W'(summary[rd_grp]);
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      rsp_data  <= rd_valid ? rd_word : '0;
    end
  end

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);

  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);

  // R8
  unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_rgn == RGN_NONE) |=> (rsp_data == '0));

  // R7
  dropped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_take && !rd_valid) |=> $stable(irq_o));

  // R4
  summary_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_rgn == RGN_SUMMARY) |=> (rsp_data[DATA_W-1:IDXS] == '0));
endmodule

// File: tb/msi_term_bank_tb_top.sv
module msi_term_bank_tb_top;
  localparam int G = 16;
  localparam int I = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_valid = 1'b0;
  logic        wr_ready, rd_ready, rsp_valid;
  logic [23:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rsp_data;
  logic [15:0] irq_o;

  int total = 0;
  int bad   = 0;
  logic [15:0] model [G][I];

  always #10 clk = ~clk;

  msi_term_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_o(irq_o));

  function automatic logic [23:0] vaddr(int g, int i);
    return 24'((g << 19) | (i << 16));
  endfunction

  function automatic logic [23:0] saddr(int g);
    return 24'h800000 | 24'(g << 16);
  endfunction

  function automatic logic [31:0] exp_sum(int g);
    logic [31:0] s = '0;
    for (int i = 0; i < I; i++) s[i] = |model[g][i];
    return s;
  endfunction

  function automatic logic [15:0] exp_irq();
    logic [15:0] q = '0;
    for (int g = 0; g < G; g++) q[g] = |exp_sum(g);
    return q;
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [23:0] a, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_valid = 1'b0;
    check(32'(rsp_valid), 32'd1, "R10 rsp_valid after read");
    d = rsp_data;
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int g = 0; g < G; g++) for (int i = 0; i < I; i++) model[g][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(32'(irq_o), 32'd0, "R9 irq after reset");
    check(32'(rsp_valid), 32'd0, "R9 rsp_valid after reset");
    check(32'(wr_ready & rd_ready), 32'd1, "R10 ready high");

    // R1 R2 R5 sweep: two vectors per register, some registers skipped
    for (int g = 0; g < G; g++)
      for (int i = 0; i < I; i++)
        if (((g + i) % 5) != 0) begin
          int v1 = (g + i) % 16;
          int v2 = (g * 3 + i * 5) % 16;
          do_write(vaddr(g, i), 32'(v1)); model[g][i][v1] = 1'b1;
          do_write(vaddr(g, i), 32'(v2)); model[g][i][v2] = 1'b1;
          check(32'(irq_o), 32'(exp_irq()), "R5 irq level during fill");
        end

    // R4 summaries
    for (int g = 0; g < G; g++) begin
      do_read(saddr(g), r);
      check(r, exp_sum(g), "R4 summary after fill");
    end

    // R7 ignored writes
    do_write(vaddr(2, 0), 32'd16);
    do_write(vaddr(3, 0), 32'hFFFF_FFFF);
    do_write(saddr(5), 32'd1);
    do_write(vaddr(7, 0) | 24'h4, 32'd2);
    check(32'(irq_o), 32'(exp_irq()), "R7 irq unchanged by dropped writes");
    do_read(saddr(2), r); check(r, exp_sum(2), "R7 summary g2 unchanged");

    // R8 unmapped reads
    do_read(24'h900000, r); check(r, 32'd0, "R8 unmapped high");
    do_read(saddr(1) | 24'h8, r); check(r, 32'd0, "R8 unmapped summary low bits");
    do_read(vaddr(1, 1) | 24'h4, r); check(r, 32'd0, "R8 unmapped vector low bits");
    check(32'(irq_o), 32'(exp_irq()), "R8 unmapped read clears nothing");

    // R6 same-cycle write and read on same register (1,1)
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = vaddr(1, 1); wr_data = 32'd9;
    rd_valid = 1'b1; rd_addr = vaddr(1, 1);
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    check(rsp_data, 32'(model[1][1]), "R6 collision returns old");
    model[1][1] = 16'h0200;
    do_read(vaddr(1, 1), r); check(r, 32'h0200, "R6 new bit survives");
    model[1][1] = '0;

    // R6 collision on different registers: write (4,2), read (4,3)
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = vaddr(4, 2); wr_data = 32'd15;
    rd_valid = 1'b1; rd_addr = vaddr(4, 3);
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0;
    check(rsp_data, 32'(model[4][3]), "R6 cross read value");
    model[4][3] = '0; model[4][2][15] = 1'b1;
    do_read(saddr(4), r); check(r, exp_sum(4), "R6 cross summary");

    // R3 drain all, then R4 late arrival and R11
    for (int g = 0; g < G; g++) begin
      for (int i = 0; i < I; i++) begin
        do_read(vaddr(g, i), r);
        check(r, 32'(model[g][i]), "R3 read-to-clear value");
        model[g][i] = '0;
      end
      do_read(vaddr(g, 0), r); check(r, 32'd0, "R3 register empty after read");
    end
    for (int g = 0; g < G; g++) begin
      do_read(saddr(g), r); check(r, 32'd0, "R11 summary zero after drain");
    end
    check(32'(irq_o), 32'd0, "R11 irq low after drain");

    do_write(vaddr(6, 7), 32'd0);
    do_read(saddr(6), r); check(r, 32'h80, "R4 late arrival visible");
    check(32'(irq_o), 32'h0040, "R5 single group irq");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule